// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block collects every interrupt request of a FIFO-equipped 16550-style serial port and turns them into one interrupt line and one status code. The sources are line-status errors, received data at the FIFO trigger, receive timeout, transmit ready, modem-status changes, Xoff or special-character detection, automatic CTS/RTS flow-control transitions and the wake-up from sleep. Event sources are caught in sticky flags. The receive-ready source is a level and follows the FIFO comparison directly.

Each pending source is masked by its enable bit. The top enabled source, by a fixed rank, is shown in a 6-bit status code. Reading that status register reports one source only, and the others wait their turn. Each source has its own clearing rule. Depending on the source, it is cleared by a register read, by the FIFO level, by a transmit write, by Xon reception or by the next received character. A status read clears only the source that the read reported. The serial shifter, the FIFOs, the baud clock and the address decoder sit outside and drive the strobes.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset `isr_code` is 6'h01 and `irq` is 0.
- R2: `irq` is 1 exactly when an enabled source is pending. With nothing pending, `isr_code` is 6'h01, and bit 0 of `isr_code` set to 1 always means "none pending".
- R3: Rank from highest to lowest, with codes: line status 6'h06, RX timeout 6'h0C, RX ready 6'h04, TX ready 6'h02, modem status 6'h00, Xoff/special 6'h10, CTS/RTS 6'h20, wake-up 6'h30. Only the top enabled pending source is shown.
- R4: `ls_evt` latches the line-status source, and `lsr_rd` clears it.
- R5: RX ready is pending while `rx_at_trig` is 1 and stops as soon as it drops. It is not latched.
- R6: `rx_tmo_evt` latches the RX timeout source, and `rhr_rd` clears it.
- R7: `tx_evt` latches TX ready. The source is cleared by `thr_wr`, or by an `isr_rd` made while TX ready is the code shown.
- R8: `msr_evt` latches the modem-status source, and `msr_rd` clears it.
- R9: Xoff is cleared by `xon_evt`. The special-character source is cleared by `rx_char_evt`. An `isr_rd` that shows 6'h10 clears both.
- R10: A CTS or RTS rise counts only while its automatic flow control is on, and `msr_rd` clears both. These sources, like Xoff/special, report only when `enh_en` is 1.
- R11: An `isr_rd` clears only the source it reported: TX ready, Xoff/special or wake-up. Every other pending source stays.
- R12: A set strobe and a clear in the same cycle leave the source pending.
- R13: A source that is latched while disabled does not raise `irq`. It becomes visible once it is enabled. The enable bits of `ier` are: bit 0 RX ready and timeout, bit 1 TX, bit 2 line status, bit 3 modem, bit 4 wake-up, bit 5 Xoff/special, bit 6 RTS, bit 7 CTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier | input | 8 | Interrupt enable bits |
| enh_en | input | 1 | Enhanced-feature enable, gates Xoff/special and CTS/RTS |
| auto_cts_en | input | 1 | Automatic CTS flow control is active |
| auto_rts_en | input | 1 | Automatic RTS flow control is active |
| rx_at_trig | input | 1 | RX FIFO level is at or above its trigger |
| ls_evt | input | 1 | Line-status error bit was set |
| rx_tmo_evt | input | 1 | Receive timeout expired |
| tx_evt | input | 1 | TX FIFO reached its trigger, or TX FIFO/transmitter empty |
| msr_evt | input | 1 | Modem-status change bit was set |
| xoff_evt | input | 1 | Xoff character received |
| xon_evt | input | 1 | Xon character received |
| spec_evt | input | 1 | Special character received |
| rx_char_evt | input | 1 | Any character received |
| cts_rise | input | 1 | CTS input went low to high |
| rts_rise | input | 1 | RTS output went low to high |
| wake_evt | input | 1 | Exit from sleep mode |
| isr_rd | input | 1 | Status register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| isr_code | output | 6 | Code of the top pending source |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 8-bit enable vector and 6-bit code, so all eight ranks and every gating bit can be reached. A scoreboard holds the expected code after each stimulus cycle. These expectations cover stacked sources that must come out in rank order one read at a time, and set/clear collisions in the same cycle. They also cover events that arrive while a source is disabled, and flow-control rises seen with automatic control off.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int ISR_W   = 6;
    localparam int NUM_LVL = 8;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int NUM_FLAG = 9;

    typedef logic [ISR_W-1:0] isr_code_t;

    // rank levels, index 0 is served first
    localparam int LVL_LS   = 0;
    localparam int LVL_TMO  = 1;
    localparam int LVL_RDY  = 2;
    localparam int LVL_TX   = 3;
    localparam int LVL_MSR  = 4;
    localparam int LVL_XS   = 5;
    localparam int LVL_FLOW = 6;
    localparam int LVL_WAKE = 7;

    // sticky flag slots
    localparam int F_LS   = 0;
    localparam int F_TMO  = 1;
    localparam int F_TX   = 2;
    localparam int F_MSR  = 3;
    localparam int F_XOFF = 4;
    localparam int F_SPEC = 5;
    localparam int F_CTS  = 6;
    localparam int F_RTS  = 7;
    localparam int F_WAKE = 8;

    // enable bit positions
    localparam int EN_RX   = 0;
    localparam int EN_TX   = 1;
    localparam int EN_LS   = 2;
    localparam int EN_MSR  = 3;
    localparam int EN_WAKE = 4;
    localparam int EN_XS   = 5;
    localparam int EN_RTS  = 6;
    localparam int EN_CTS  = 7;

    localparam isr_code_t CODE_NONE = 6'h01;
    localparam isr_code_t CODE_LS   = 6'h06;
    localparam isr_code_t CODE_TMO  = 6'h0C;
    localparam isr_code_t CODE_RDY  = 6'h04;
    localparam isr_code_t CODE_TX   = 6'h02;
    localparam isr_code_t CODE_MSR  = 6'h00;
    localparam isr_code_t CODE_XS   = 6'h10;
    localparam isr_code_t CODE_FLOW = 6'h20;
    localparam isr_code_t CODE_WAKE = 6'h30;

    typedef struct packed {
        logic [NUM_FLAG-1:0] set;
        logic [NUM_FLAG-1:0] clr;
    } flag_ctl_t;

    function automatic isr_code_t code_of(input logic [LVL_W-1:0] lvl);
        case (lvl)
            3'd0:    code_of = CODE_LS;
            3'd1:    code_of = CODE_TMO;
            3'd2:    code_of = CODE_RDY;
            3'd3:    code_of = CODE_TX;
            3'd4:    code_of = CODE_MSR;
            3'd5:    code_of = CODE_XS;
            3'd6:    code_of = CODE_FLOW;
            default: code_of = CODE_WAKE;
        endcase
    endfunction

endpackage

// File: rtl/irq_flag.sv
module irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // a new event outlives a same-cycle clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

    assert_clear_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
#(
    parameter int N_LVL = NUM_LVL,
    localparam int L_W  = $clog2(N_LVL)
) (
    input  logic [N_LVL-1:0] pend_i,
    output logic             valid_o,
    output logic [L_W-1:0]   lvl_o,
    output isr_code_t        code_o
);

    always_comb begin
        lvl_o = '0;
        for (int i = N_LVL - 1; i >= 0; i--) begin
            if (pend_i[i]) lvl_o = i[L_W-1:0];
        end
        valid_o = |pend_i;
        code_o  = valid_o ? code_of(lvl_o) : CODE_NONE;
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int IER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IER_W-1:0] ier,
    input  logic             enh_en,
    input  logic             auto_cts_en,
    input  logic             auto_rts_en,
    input  logic             rx_at_trig,
    input  logic             ls_evt,
    input  logic             rx_tmo_evt,
    input  logic             tx_evt,
    input  logic             msr_evt,
    input  logic             xoff_evt,
    input  logic             xon_evt,
    input  logic             spec_evt,
    input  logic             rx_char_evt,
    input  logic             cts_rise,
    input  logic             rts_rise,
    input  logic             wake_evt,
    input  logic             isr_rd,
    input  logic             lsr_rd,
    input  logic             msr_rd,
    input  logic             rhr_rd,
    input  logic             thr_wr,
    output logic [ISR_W-1:0] isr_code,
    output logic             irq
);

    flag_ctl_t           ctl_d;
    logic [NUM_FLAG-1:0] flag_q;
    logic [NUM_LVL-1:0]  pend;
    logic                top_valid;
    logic [LVL_W-1:0]    top_lvl;
    isr_code_t           top_code;
    logic                rd_hit;

    // ---- sticky sources ----
    for (genvar g = 0; g < NUM_FLAG; g++) begin : g_flag
        irq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (ctl_d.set[g]),
            .clr_i  (ctl_d.clr[g]),
            .flag_o (flag_q[g])
        );
    end

    // ---- enable masking and ranking ----
    always_comb begin
        pend           = '0;
        pend[LVL_LS]   = flag_q[F_LS]  & ier[EN_LS];
        pend[LVL_TMO]  = flag_q[F_TMO] & ier[EN_RX];
        pend[LVL_RDY]  = rx_at_trig    & ier[EN_RX];
        pend[LVL_TX]   = flag_q[F_TX]  & ier[EN_TX];
        pend[LVL_MSR]  = flag_q[F_MSR] & ier[EN_MSR];
        pend[LVL_XS]   = (flag_q[F_XOFF] | flag_q[F_SPEC]) & ier[EN_XS] & enh_en;
        pend[LVL_FLOW] = ((flag_q[F_CTS] & ier[EN_CTS]) |
                          (flag_q[F_RTS] & ier[EN_RTS])) & enh_en;
        pend[LVL_WAKE] = flag_q[F_WAKE] & ier[EN_WAKE];
    end

    irq_prio_enc #(.N_LVL(NUM_LVL)) u_enc (
        .pend_i  (pend),
        .valid_o (top_valid),
        .lvl_o   (top_lvl),
        .code_o  (top_code)
    );

    // ---- set / clear rules ----
    always_comb begin
        rd_hit = isr_rd & top_valid;
        ctl_d  = '0;

        ctl_d.set[F_LS]   = ls_evt;
        ctl_d.clr[F_LS]   = lsr_rd;

        ctl_d.set[F_TMO]  = rx_tmo_evt;
        ctl_d.clr[F_TMO]  = rhr_rd;

        ctl_d.set[F_TX]   = tx_evt;
        ctl_d.clr[F_TX]   = thr_wr | (rd_hit && top_lvl == LVL_W'(LVL_TX));

        ctl_d.set[F_MSR]  = msr_evt;
        ctl_d.clr[F_MSR]  = msr_rd;

        ctl_d.set[F_XOFF] = xoff_evt;
        ctl_d.clr[F_XOFF] = xon_evt | (rd_hit && top_lvl == LVL_W'(LVL_XS));

        ctl_d.set[F_SPEC] = spec_evt;
        ctl_d.clr[F_SPEC] = rx_char_evt | (rd_hit && top_lvl == LVL_W'(LVL_XS));

        ctl_d.set[F_CTS]  = cts_rise & auto_cts_en;
        ctl_d.clr[F_CTS]  = msr_rd;

        ctl_d.set[F_RTS]  = rts_rise & auto_rts_en;
        ctl_d.clr[F_RTS]  = msr_rd;

        ctl_d.set[F_WAKE] = wake_evt;
        ctl_d.clr[F_WAKE] = rd_hit && top_lvl == LVL_W'(LVL_WAKE);
    end

    assign isr_code = top_code;
    assign irq      = top_valid;

    // ---- checks ----
    assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (isr_code == CODE_NONE && !irq));

    assert_busy_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> (irq && !isr_code[0]));

    assert_rxrdy_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_at_trig && ier[EN_RX] && !(flag_q[F_LS] && ier[EN_LS]) && !flag_q[F_TMO])
        |-> isr_code == CODE_RDY);

    assert_lsr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !ls_evt) |=> !flag_q[F_LS]);

    assert_tmo_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rhr_rd && !rx_tmo_evt) |=> !flag_q[F_TMO]);

    assert_msr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !msr_evt) |=> !flag_q[F_MSR]);

    assert_flow_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_en |-> (isr_code != CODE_FLOW && isr_code != CODE_XS));

    assert_read_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && flag_q[F_TX] && isr_code != CODE_TX && !thr_wr) |=> flag_q[F_TX]);

endmodule

// File: tb/sim_uart_irq_prio.sv
module sim_uart_irq_prio;

    localparam int IER_W = 8;

    localparam logic [5:0] C_NONE = 6'h01, C_LS = 6'h06, C_TMO = 6'h0C, C_RDY = 6'h04,
                           C_TX = 6'h02, C_MSR = 6'h00, C_XS = 6'h10, C_FLOW = 6'h20,
                           C_WAKE = 6'h30;

    // strobe mask positions
    localparam int S_LS = 0, S_TMO = 1, S_TX = 2, S_MSR = 3, S_XOFF = 4, S_XON = 5,
                   S_SPEC = 6, S_CHR = 7, S_CTS = 8, S_RTS = 9, S_WAKE = 10,
                   S_ISR = 11, S_LSR = 12, S_MSRRD = 13, S_RHR = 14, S_THR = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IER_W-1:0] ier = '0;
    logic enh_en = 1'b0, auto_cts_en = 1'b0, auto_rts_en = 1'b0, rx_at_trig = 1'b0;
    logic [15:0] stb = '0;
    logic [5:0] isr_code;
    logic irq;

    always #2 clk = ~clk;   // 250 MHz

    uart_irq_prio #(.IER_W(IER_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ier(ier), .enh_en(enh_en),
        .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en), .rx_at_trig(rx_at_trig),
        .ls_evt(stb[S_LS]), .rx_tmo_evt(stb[S_TMO]), .tx_evt(stb[S_TX]),
        .msr_evt(stb[S_MSR]), .xoff_evt(stb[S_XOFF]), .xon_evt(stb[S_XON]),
        .spec_evt(stb[S_SPEC]), .rx_char_evt(stb[S_CHR]), .cts_rise(stb[S_CTS]),
        .rts_rise(stb[S_RTS]), .wake_evt(stb[S_WAKE]), .isr_rd(stb[S_ISR]),
        .lsr_rd(stb[S_LSR]), .msr_rd(stb[S_MSRRD]), .rhr_rd(stb[S_RHR]),
        .thr_wr(stb[S_THR]), .isr_code(isr_code), .irq(irq)
    );

    typedef struct {
        logic [5:0] code;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;

    // monitor: compares each expectation as soon as it is posted
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            n_chk++;
            if (isr_code !== e.code || irq !== (e.code != C_NONE)) begin
                n_bad++;
                $display("FAIL %s: isr_code=%h irq=%b expected isr_code=%h irq=%b",
                         e.tag, isr_code, irq, e.code, (e.code != C_NONE));
            end
        end
    end

    // driver: one cycle of strobes, then post the code expected after that edge
    task automatic step(input logic [15:0] s, input logic [5:0] code, input string tag);
        exp_t e;
        @(negedge clk);
        stb = s;
        @(posedge clk);
        @(negedge clk);
        stb = '0;
        e.code = code;
        e.tag  = tag;
        exp_q.push_back(e);
        #0;
    endtask

    function automatic logic [15:0] m(input int a, input int b = -1);
        logic [15:0] r = '0;
        r[a] = 1'b1;
        if (b >= 0) r[b] = 1'b1;
        return r;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step('0, C_NONE, "R1 reset state");

        ier = 8'hFF; enh_en = 1'b1; auto_cts_en = 1'b1; auto_rts_en = 1'b1;
        step(m(S_LS),  C_LS,  "R4 line status set");
        step(m(S_TMO), C_LS,  "R3 line status above timeout");
        step(m(S_LSR), C_TMO, "R4 lsr read clears, R3 timeout next");
        rx_at_trig = 1'b1;
        step('0,       C_TMO, "R3 timeout above rx ready");
        step(m(S_RHR), C_RDY, "R6 rhr read clears timeout");
        rx_at_trig = 1'b0;
        step('0,       C_NONE, "R5 rx ready follows level");

        step(m(S_TX),  C_TX,   "R7 tx ready set");
        step(m(S_THR), C_NONE, "R7 thr write clears");
        step(m(S_TX, S_MSR), C_TX, "R3 tx above modem");
        step(m(S_ISR), C_MSR,  "R7 status read clears reported tx, R11 modem kept");
        step(m(S_MSRRD), C_NONE, "R8 msr read clears");

        step(m(S_XOFF), C_XS,  "R9 xoff set");
        step(m(S_XON),  C_NONE, "R9 xon clears xoff");
        step(m(S_SPEC), C_XS,  "R9 special set");
        step(m(S_CHR),  C_NONE, "R9 next char clears special");
        step(m(S_SPEC, S_CHR), C_XS, "R12 special set beats char clear");
        step(m(S_ISR),  C_NONE, "R9 status read clears xoff/special");

        step(m(S_CTS),   C_FLOW, "R10 cts rise");
        step(m(S_MSRRD), C_NONE, "R10 msr read clears cts");
        enh_en = 1'b0;
        step(m(S_CTS),   C_NONE, "R10 cts hidden without enhanced bit");
        enh_en = 1'b1;
        step('0,         C_FLOW, "R13 latched cts shows once enabled");
        step(m(S_MSRRD), C_NONE, "R10 msr read clears again");
        auto_rts_en = 1'b0;
        step(m(S_RTS),   C_NONE, "R10 rts rise ignored without auto rts");
        auto_rts_en = 1'b1;
        step('0,         C_NONE, "R10 rts not latched when auto off");
        step(m(S_RTS),   C_FLOW, "R10 rts rise with auto rts");
        step(m(S_MSRRD), C_NONE, "R10 msr read clears rts");

        step(m(S_WAKE), C_WAKE, "R3 wake-up lowest");
        step(m(S_TX),   C_TX,   "R3 tx above wake-up");
        step(m(S_ISR),  C_WAKE, "R11 read clears only tx");
        step(m(S_ISR),  C_NONE, "R11 read clears wake-up");

        step(m(S_LS, S_LSR), C_LS, "R12 line event beats lsr read");
        step(m(S_LSR),  C_NONE, "R4 lsr read clears");

        ier = 8'h00;
        step(m(S_MSR),  C_NONE, "R13 disabled modem source silent");
        ier = 8'hFF;
        step('0,        C_MSR,  "R13 modem visible after enable");
        step(m(S_MSRRD), C_NONE, "R8 msr read clears");

        step(m(S_TX),   C_TX,   "R7 tx set");
        step(m(S_TX, S_ISR), C_TX, "R12 tx event beats reported read");
        step(m(S_THR),  C_NONE, "R7 thr write clears");

        step(m(S_ISR),  C_NONE, "R2 read with nothing pending");

        #1;
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule